// File: doc/BRIEF.md
# Local-Port Cipher Firewall

This block sits between a processing element's network interface and the local port of a mesh router. It carries 32-bit flits in both directions at once. Toward the router it offers the same valid/ready flit port that the interface would offer, and toward the interface it offers the same port that the router would offer. Neither neighbour has to change.

Each packet starts with a header flit and a size flit. Bit 31 of the header marks a packet of a secure application. The payload of a marked packet goes through a shared block-cipher engine in ECB fashion: outbound traffic (interface to router) is encrypted and inbound traffic (router to interface) is decrypted, with one 128-bit application key. Unmarked packets are forwarded through a single register stage.

Each direction has its own control state machine and datapath. An arbiter lends the single engine to one direction at a time, one four-word block per grant. When both directions are waiting, the arbiter alternates between them. The engine in this project is a stand-in with the real handshake: two key halves and two data halves are loaded on consecutive cycles, start follows, and done rises a fixed latency later. Its transform is a bitwise XOR of the block with the key, so encryption and decryption are the same operation.

Top module: `fw_firewall`

## Requirements
- R1: After reset, neither flit output (router side or interface side) is valid, and no flit is delivered until a packet is offered.
- R2: A packet whose header bit 31 is 0 is forwarded with all flits unchanged, and in the same order. A flit accepted at a clock edge is presented on the far output from the next cycle on.
- R3: The header flit and the size flit are never ciphered, in both plain and secure packets. A secure packet of size 0 consists only of these two flits.
- R4: In a secure outbound packet the payload is grouped into blocks of four flits, with block word 0 in bits 127:96. Each output word i of a block equals the input word XOR key bits [127-32i -: 32].
- R5: When a secure outbound payload is not a multiple of four flits, the final block is filled with zero words before ciphering. The router therefore receives ceil(size/4)*4 payload flits, and the size flit is unchanged.
- R6: A secure inbound packet carries ceil(size/4)*4 payload flits on the router side. The interface receives only the first size decrypted flits (word XOR key word), and the padding words are dropped.
- R7: The two directions progress independently. A plain inbound packet is delivered while an outbound secure packet is still waiting on the engine.
- R8: The engine is granted to at most one direction at a time. When the owner releases it while the other direction is requesting, the other direction receives the next grant.
- R9: Every block uses the engine handshake in this order: four load cycles (key high half, key low half, data high half, data low half), then a start cycle. Done rises exactly CipherLat cycles after start, and only the direction that owns the engine drives it.
- R10: While an output is valid and its ready is low, the flit on it stays valid and unchanged.
- R11: Only header bit 31 selects ciphering. A header whose other bits are all ones but whose bit 31 is 0 is treated as plain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| appKey | input | 128 | Application key used for every ciphered block |
| niTxData | input | 32 | Outbound flit from the network interface |
| niTxValid | input | 1 | Outbound flit valid |
| niTxReady | output | 1 | Firewall accepts the outbound flit |
| rtTxData | output | 32 | Flit toward the router local port |
| rtTxValid | output | 1 | Flit toward router valid |
| rtTxReady | input | 1 | Router accepts the flit |
| rtRxData | input | 32 | Inbound flit from the router local port |
| rtRxValid | input | 1 | Inbound flit valid |
| rtRxReady | output | 1 | Firewall accepts the inbound flit |
| niRxData | output | 32 | Flit toward the network interface |
| niRxValid | output | 1 | Flit toward interface valid |
| niRxReady | input | 1 | Interface accepts the flit |

## Verification
A plain flit is due on the far side one cycle after the edge that accepts it. The bench checks this directly on the falling edge that follows acceptance, and for held-off outputs it checks that the flit stays stable over several falling edges. A secure block leaves only after its last word is gathered, then one request cycle, the grant, four loads, start and CipherLat cycles to done, capture, and one emitted word per cycle. Because that latency shifts with contention, a scoreboard compares every delivered flit in order, whatever the cycle in which it is delivered. Ordering between the directions is checked from the recorded delivery cycles, not from absolute counts.

// File: rtl/fw_pkg.sv
package fw_pkg;
  parameter int FlitW    = 32;
  parameter int BlkWords = 4;
  localparam int BlkW  = FlitW * BlkWords;
  localparam int HalfW = BlkW / 2;
  localparam int IdxW  = $clog2(BlkWords);

  // strobes from a direction's control to its datapath
  typedef struct packed {
    logic            takeIn;   // input flit into output register
    logic            bufWr;    // input flit into block buffer
    logic            bufZero;  // pad word into block buffer
    logic            bufCap;   // engine result into block buffer
    logic            emit;     // block buffer word into output register
    logic [IdxW-1:0] idx;      // buffer word or load phase
  } dpStrobe_t;

  typedef struct packed {
    logic             load;
    logic             start;
    logic [HalfW-1:0] word;
  } engReq_t;
endpackage

// File: rtl/fw_cipher_engine.sv
module fw_cipher_engine
  import fw_pkg::*;
#(
  parameter int Latency = 13
) (
  input  logic            clk,
  input  logic            rstN,
  input  engReq_t         req,
  output logic            done,
  output logic [BlkW-1:0] result
);
  localparam int TmrW = $clog2(Latency + 1);

  logic [BlkW-1:0] keyReg, dataReg;
  logic [1:0]      loadCnt;
  logic [TmrW-1:0] timer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyReg  <= '0;
      dataReg <= '0;
      loadCnt <= '0;
      timer   <= '0;
    end else if (req.start) begin
      loadCnt <= '0;
      timer   <= TmrW'(Latency);
    end else begin
      if (timer != '0) timer <= timer - 1'b1;
      if (req.load) begin
        loadCnt <= loadCnt + 1'b1;
        case (loadCnt)
          2'd0:    keyReg[BlkW-1:HalfW]  <= req.word;
          2'd1:    keyReg[HalfW-1:0]     <= req.word;
          2'd2:    dataReg[BlkW-1:HalfW] <= req.word;
          default: dataReg[HalfW-1:0]    <= req.word;
        endcase
      end
    end
  end

  assign done   = (timer == TmrW'(1));
  assign result = dataReg ^ keyReg;

  // independent cycle count since the last start
  logic [TmrW:0] sinceStart;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceStart <= '0;
    else if (req.start) sinceStart <= (TmrW+1)'(1);
    else if (sinceStart != '0 && sinceStart <= (TmrW+1)'(Latency))
      sinceStart <= sinceStart + 1'b1;
  end

  // R9
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> sinceStart == (TmrW+1)'(Latency));
  // R9
  start_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    req.start |-> $past(req.load));
endmodule

// File: rtl/fw_arbiter.sv
module fw_arbiter (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] req,
  output logic [1:0] gnt
);
  logic [1:0] owner;
  logic       lastSel, free, fire, pick;

  // engine is free when nobody owns it or the owner has let go
  assign free = (owner & req) == 2'b00;

  always_comb begin
    fire = free && (req != 2'b00);
    if (req == 2'b11) pick = ~lastSel;
    else              pick = req[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owner   <= 2'b00;
      lastSel <= 1'b1;
    end else if (free) begin
      owner <= fire ? (pick ? 2'b10 : 2'b01) : 2'b00;
      if (fire) lastSel <= pick;
    end
  end

  assign gnt = owner;

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gnt));
  // R8
  handover_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gnt[0] && !req[0] && req[1]) |=> gnt[1]);
  // R8
  handover_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gnt[1] && !req[1] && req[0]) |=> gnt[0]);
endmodule

// File: rtl/fw_dir_ctrl.sv
module fw_dir_ctrl
  import fw_pkg::*;
#(
  parameter bit Outbound = 1'b1,
  parameter int SizeW    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             hdrFlag,
  input  logic [SizeW-1:0] sizeField,
  output logic             inReady,
  input  logic             outValid,
  input  logic             outReady,
  input  logic             gnt,
  input  logic             engDone,
  output logic             engReqOn,
  output logic             engLoad,
  output logic             engStart,
  output dpStrobe_t        st
);
  typedef enum logic [3:0] {
    S_HDR, S_SIZE, S_PLAIN, S_GATH, S_REQ, S_LOAD, S_START, S_WAIT, S_EMIT
  } state_t;

  localparam logic [IdxW:0]   BlkCnt  = (IdxW+1)'(BlkWords);
  localparam logic [IdxW-1:0] LastIdx = IdxW'(BlkWords - 1);

  state_t          state, nextState;
  logic            secure;
  logic [SizeW-1:0] rem;
  logic [IdxW-1:0] idx;
  logic [IdxW:0]   idxExt, blkReal, gatherN, emitN;
  logic            outFree, advance, lastEmit, take;

  assign outFree  = !outValid || outReady;
  assign idxExt   = {1'b0, idx};
  assign blkReal  = (rem >= SizeW'(BlkWords)) ? BlkCnt : rem[IdxW:0];
  assign gatherN  = Outbound ? blkReal : BlkCnt;
  assign emitN    = Outbound ? BlkCnt : blkReal;
  assign lastEmit = (idxExt + 1'b1) == emitN;
  assign take     = inValid && outFree;

  always_comb begin
    st        = '0;
    inReady   = 1'b0;
    engReqOn  = 1'b0;
    engLoad   = 1'b0;
    engStart  = 1'b0;
    advance   = 1'b0;
    nextState = state;
    case (state)
      S_HDR: begin
        inReady = outFree;
        if (take) begin
          st.takeIn = 1'b1;
          nextState = S_SIZE;
        end
      end
      S_SIZE: begin
        inReady = outFree;
        if (take) begin
          st.takeIn = 1'b1;
          if (sizeField == '0) nextState = S_HDR;
          else if (secure)     nextState = S_GATH;
          else                 nextState = S_PLAIN;
        end
      end
      S_PLAIN: begin
        inReady = outFree;
        if (take) begin
          st.takeIn = 1'b1;
          if (rem == SizeW'(1)) nextState = S_HDR;
        end
      end
      S_GATH: begin
        st.idx = idx;
        if (idxExt < gatherN) begin
          inReady = 1'b1;
          if (inValid) begin
            st.bufWr = 1'b1;
            advance  = 1'b1;
          end
        end else begin
          st.bufZero = 1'b1;
          advance    = 1'b1;
        end
        if (advance && idx == LastIdx) nextState = S_REQ;
      end
      S_REQ: begin
        engReqOn = 1'b1;
        if (gnt) nextState = S_LOAD;
      end
      S_LOAD: begin
        engReqOn = 1'b1;
        engLoad  = 1'b1;
        st.idx   = idx;
        if (idx == LastIdx) nextState = S_START;
      end
      S_START: begin
        engReqOn  = 1'b1;
        engStart  = 1'b1;
        nextState = S_WAIT;
      end
      S_WAIT: begin
        engReqOn = 1'b1;
        if (engDone) begin
          st.bufCap = 1'b1;
          nextState = S_EMIT;
        end
      end
      S_EMIT: begin
        st.idx = idx;
        if (outFree) begin
          st.emit = 1'b1;
          if (lastEmit)
            nextState = (rem == SizeW'(blkReal)) ? S_HDR : S_GATH;
        end
      end
      default: nextState = S_HDR;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_HDR;
      secure <= 1'b0;
      rem    <= '0;
      idx    <= '0;
    end else begin
      state <= nextState;
      case (state)
        S_HDR:   if (take) secure <= hdrFlag;
        S_SIZE:  if (take) rem <= sizeField;
        S_PLAIN: if (take) rem <= rem - 1'b1;
        S_GATH:  if (advance) idx <= idx + 1'b1;
        S_LOAD:  idx <= idx + 1'b1;
        S_EMIT: begin
          if (outFree) begin
            if (lastEmit) begin
              idx <= '0;
              rem <= rem - SizeW'(blkReal);
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R9
  eng_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (engLoad || engStart) |-> gnt);
endmodule

// File: rtl/fw_dir_dpath.sv
module fw_dir_dpath
  import fw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        st,
  input  logic [FlitW-1:0] inData,
  input  logic [BlkW-1:0]  key,
  input  logic [BlkW-1:0]  engResult,
  input  logic             outReady,
  output logic             outValid,
  output logic [FlitW-1:0] outData,
  output logic [HalfW-1:0] engWord
);
  logic [FlitW-1:0] blkBuf [BlkWords];
  logic [BlkW-1:0]  blkFlat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      for (int i = 0; i < BlkWords; i++) blkBuf[i] <= '0;
    end else begin
      if (st.takeIn) begin
        outData  <= inData;
        outValid <= 1'b1;
      end else if (st.emit) begin
        outData  <= blkBuf[st.idx];
        outValid <= 1'b1;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
      if (st.bufWr) blkBuf[st.idx] <= inData;
      else if (st.bufZero) blkBuf[st.idx] <= '0;
      else if (st.bufCap)
        for (int i = 0; i < BlkWords; i++)
          blkBuf[i] <= engResult[BlkW-1-i*FlitW -: FlitW];
    end
  end

  always_comb begin
    for (int i = 0; i < BlkWords; i++)
      blkFlat[BlkW-1-i*FlitW -: FlitW] = blkBuf[i];
  end

  // load phases: key high, key low, block high, block low
  always_comb begin
    case (st.idx)
      IdxW'(0): engWord = key[BlkW-1:HalfW];
      IdxW'(1): engWord = key[HalfW-1:0];
      IdxW'(2): engWord = blkFlat[BlkW-1:HalfW];
      default:  engWord = blkFlat[HalfW-1:0];
    endcase
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));
endmodule

// File: rtl/fw_firewall.sv
module fw_firewall
  import fw_pkg::*;
#(
  parameter int SecureBit = 31,
  parameter int SizeW     = 16,
  parameter int CipherLat = 13
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [127:0] appKey,
  input  logic [31:0]  niTxData,
  input  logic         niTxValid,
  output logic         niTxReady,
  output logic [31:0]  rtTxData,
  output logic         rtTxValid,
  input  logic         rtTxReady,
  input  logic [31:0]  rtRxData,
  input  logic         rtRxValid,
  output logic         rtRxReady,
  output logic [31:0]  niRxData,
  output logic         niRxValid,
  input  logic         niRxReady
);
  localparam int NumDir = 2;  // 0: outbound, 1: inbound

  logic [NumDir-1:0] inValidV, inReadyV, outValidV, outReadyV;
  logic [NumDir-1:0] reqV, gntV, loadV, startV, doneV;
  logic [FlitW-1:0]  inDataV  [NumDir];
  logic [FlitW-1:0]  outDataV [NumDir];
  logic [HalfW-1:0]  wordV    [NumDir];
  dpStrobe_t         stV      [NumDir];
  engReq_t           engReq;
  logic              engDone;
  logic [BlkW-1:0]   engResult;

  assign inValidV   = {rtRxValid, niTxValid};
  assign outReadyV  = {niRxReady, rtTxReady};
  assign inDataV[0] = niTxData;
  assign inDataV[1] = rtRxData;
  assign niTxReady  = inReadyV[0];
  assign rtRxReady  = inReadyV[1];
  assign rtTxValid  = outValidV[0];
  assign rtTxData   = outDataV[0];
  assign niRxValid  = outValidV[1];
  assign niRxData   = outDataV[1];

  for (genvar d = 0; d < NumDir; d++) begin : g_dir
    fw_dir_ctrl #(.Outbound(d == 0), .SizeW(SizeW)) u_ctrl (
      .clk      (clk),
      .rstN     (rstN),
      .inValid  (inValidV[d]),
      .hdrFlag  (inDataV[d][SecureBit]),
      .sizeField(inDataV[d][SizeW-1:0]),
      .inReady  (inReadyV[d]),
      .outValid (outValidV[d]),
      .outReady (outReadyV[d]),
      .gnt      (gntV[d]),
      .engDone  (doneV[d]),
      .engReqOn (reqV[d]),
      .engLoad  (loadV[d]),
      .engStart (startV[d]),
      .st       (stV[d])
    );
    fw_dir_dpath u_dpath (
      .clk      (clk),
      .rstN     (rstN),
      .st       (stV[d]),
      .inData   (inDataV[d]),
      .key      (appKey),
      .engResult(engResult),
      .outReady (outReadyV[d]),
      .outValid (outValidV[d]),
      .outData  (outDataV[d]),
      .engWord  (wordV[d])
    );
    assign doneV[d] = engDone && gntV[d];
  end

  fw_arbiter u_arb (
    .clk (clk),
    .rstN(rstN),
    .req (reqV),
    .gnt (gntV)
  );

  always_comb begin
    engReq = '0;
    for (int d = 0; d < NumDir; d++) begin
      if (gntV[d]) begin
        engReq.load  = loadV[d];
        engReq.start = startV[d];
        engReq.word  = wordV[d];
      end
    end
  end

  fw_cipher_engine #(.Latency(CipherLat)) u_eng (
    .clk   (clk),
    .rstN  (rstN),
    .req   (engReq),
    .done  (engDone),
    .result(engResult)
  );
endmodule

// File: tb/fw_firewall_test.sv
`timescale 1ns/1ps
module fw_firewall_test;
  localparam logic [127:0] Key = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
  localparam int WatchLimit = 100000;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] niTxData, rtRxData;
  logic        niTxValid, rtRxValid, rtTxReady, niRxReady;
  logic [31:0] rtTxData, niRxData;
  logic        niTxReady, rtTxValid, rtRxReady, niRxValid;

  always #4 clk = ~clk;

  fw_firewall uut (
    .clk(clk), .rstN(rstN), .appKey(Key),
    .niTxData(niTxData), .niTxValid(niTxValid), .niTxReady(niTxReady),
    .rtTxData(rtTxData), .rtTxValid(rtTxValid), .rtTxReady(rtTxReady),
    .rtRxData(rtRxData), .rtRxValid(rtRxValid), .rtRxReady(rtRxReady),
    .niRxData(niRxData), .niRxValid(niRxValid), .niRxReady(niRxReady)
  );

  int nChecks = 0;
  int nFail   = 0;
  int cycle   = 0;
  logic [31:0] expRt[$], expNi[$];
  string       tagRt[$], tagNi[$];
  int cycRt[64], cycNi[64];
  int cntRt = 0, cntNi = 0;

  function automatic logic [31:0] kw(input int i);
    return Key[127-32*i -: 32];
  endfunction

  function automatic logic [31:0] pay(input logic [31:0] base, input int j);
    return base + 32'(j) * 32'h01030507;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cycle++;

  always @(posedge clk) begin
    if (cycle > WatchLimit) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycle, WatchLimit);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  // scoreboard monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      if (rtTxValid && rtTxReady) begin
        if (expRt.size() == 0) check("R2 router side extra flit", rtTxData, 32'hdead_dead);
        else check(tagRt.pop_front(), rtTxData, expRt.pop_front());
        if (cntRt < 64) cycRt[cntRt] = cycle;
        cntRt++;
      end
      if (niRxValid && niRxReady) begin
        if (expNi.size() == 0) check("R2 interface side extra flit", niRxData, 32'hdead_dead);
        else check(tagNi.pop_front(), niRxData, expNi.pop_front());
        if (cntNi < 64) cycNi[cntNi] = cycle;
        cntNi++;
      end
    end
  end

  task automatic pushNi(input logic [31:0] f);
    niTxData  = f;
    niTxValid = 1'b1;
    forever begin
      @(negedge clk);
      if (niTxReady) break;
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    niTxValid = 1'b0;
  endtask

  task automatic pushRt(input logic [31:0] f);
    rtRxData  = f;
    rtRxValid = 1'b1;
    forever begin
      @(negedge clk);
      if (rtRxReady) break;
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    rtRxValid = 1'b0;
  endtask

  // outbound: interface -> router
  task automatic sendOut(input logic [31:0] hdr, input int n, input logic [31:0] base);
    int blocks = (n + 3) / 4;
    expRt.push_back(hdr);         tagRt.push_back(hdr[31] ? "R3 header" : "R2 header");
    expRt.push_back(32'(n));      tagRt.push_back(hdr[31] ? "R3 size" : "R2 size");
    if (hdr[31]) begin
      for (int j = 0; j < blocks * 4; j++) begin
        expRt.push_back((j < n ? pay(base, j) : 32'h0) ^ kw(j % 4));
        tagRt.push_back(j < n ? "R4 cipher word" : "R5 pad word");
      end
    end else begin
      for (int j = 0; j < n; j++) begin
        expRt.push_back(pay(base, j));
        tagRt.push_back(hdr[30:0] == '1 ? "R11 plain word" : "R2 plain word");
      end
    end
    pushNi(hdr);
    pushNi(32'(n));
    for (int j = 0; j < n; j++) pushNi(pay(base, j));
  endtask

  // inbound: router -> interface
  task automatic sendIn(input logic [31:0] hdr, input int n, input logic [31:0] base);
    int wire_n = hdr[31] ? ((n + 3) / 4) * 4 : n;
    expNi.push_back(hdr);         tagNi.push_back(hdr[31] ? "R3 header" : "R2 header");
    expNi.push_back(32'(n));      tagNi.push_back(hdr[31] ? "R3 size" : "R2 size");
    for (int j = 0; j < n; j++) begin
      expNi.push_back(hdr[31] ? (pay(base, j) ^ kw(j % 4)) : pay(base, j));
      tagNi.push_back(hdr[31] ? "R6 plain word" : "R7 plain word");
    end
    pushRt(hdr);
    pushRt(32'(n));
    for (int j = 0; j < wire_n; j++) pushRt(pay(base, j));
  endtask

  task automatic drain();
    while (expRt.size() != 0 || expNi.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    rstN = 1'b0;
    niTxData = '0; rtRxData = '0;
    niTxValid = 1'b0; rtRxValid = 1'b0;
    rtTxReady = 1'b1; niRxReady = 1'b1;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: idle outputs after reset
    check("R1 router valid", 32'(rtTxValid), 32'h0);
    check("R1 interface valid", 32'(niRxValid), 32'h0);
    @(posedge clk); #1;

    // R2: one-cycle latency on a plain header
    expRt.push_back(32'h0000_0102); tagRt.push_back("R2 header");
    pushNi(32'h0000_0102);
    @(negedge clk);
    check("R2 latency valid", 32'(rtTxValid), 32'h1);
    check("R2 latency data", rtTxData, 32'h0000_0102);
    @(posedge clk); #1;
    expRt.push_back(32'd3); tagRt.push_back("R2 size");
    for (int j = 0; j < 3; j++) begin expRt.push_back(pay(32'h11, j)); tagRt.push_back("R2 plain word"); end
    pushNi(32'd3);
    for (int j = 0; j < 3; j++) pushNi(pay(32'h11, j));
    drain();

    // R11: all header bits but bit 31 set -> plain
    sendOut(32'h7fff_ffff, 2, 32'h2200_0000);
    sendIn(32'h0000_0203, 5, 32'h3300_0000);
    drain();

    // R4/R5/R3: secure outbound with various sizes
    sendOut(32'h8000_0301, 8, 32'h4400_0000);
    sendOut(32'h8000_0302, 5, 32'h5500_0000);
    sendOut(32'h8000_0303, 4, 32'h6600_0000);
    sendOut(32'h8000_0304, 0, 32'h0);
    drain();

    // R6: secure inbound, padding dropped
    sendIn(32'h8000_0401, 8, 32'h7700_0000);
    sendIn(32'h8000_0402, 6, 32'h8800_0000);
    sendIn(32'h8000_0403, 1, 32'h9900_0000);
    drain();

    // R8: both directions contend for the engine
    cntRt = 0; cntNi = 0;
    fork
      sendOut(32'h8000_0501, 8, 32'haa00_0000);
      sendIn(32'h8000_0502, 8, 32'hbb00_0000);
    join
    drain();
    check("R8 inbound first word before outbound second block",
          32'(cycNi[2] < cycRt[6]), 32'h1);
    check("R8 outbound first word before inbound second block",
          32'(cycRt[2] < cycNi[6]), 32'h1);

    // R7: plain inbound overtakes a secure outbound waiting on the engine
    cntRt = 0; cntNi = 0;
    fork
      sendOut(32'h8000_0601, 4, 32'hcc00_0000);
      sendIn(32'h0000_0602, 6, 32'hdd00_0000);
    join
    drain();
    check("R7 plain inbound done before outbound payload",
          32'(cycNi[7] < cycRt[2]), 32'h1);

    // R10: hold under back-pressure
    rtTxReady = 1'b0;
    fork
      sendOut(32'h0000_0701, 2, 32'hee00_0000);
      begin
        repeat (3) @(negedge clk);
        check("R10 held valid", 32'(rtTxValid), 32'h1);
        check("R10 held data", rtTxData, 32'h0000_0701);
        repeat (3) @(negedge clk);
        check("R10 still held data", rtTxData, 32'h0000_0701);
        check("R10 input stalled", 32'(niTxReady), 32'h0);
        @(posedge clk); #1;
        rtTxReady = 1'b1;
      end
    join
    drain();

    check("R7 router queue drained", 32'(expRt.size()), 32'h0);
    check("R7 interface queue drained", 32'(expNi.size()), 32'h0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule